// File: doc/BRIEF.md
# Two-Bit Slice Table-Driven Pattern Automaton Tile

This block is one small, table-driven automaton of a string-scanning engine. A full byte-wide matching automaton is split into several narrow automata, each of which sees only a 2-bit slice of every payload byte. This tile is one of those narrow automata. Each of its states has exactly four outgoing edges, one per value of the slice. Failure transitions are already folded into the stored edges, so every state always has a full set of successors.

A table of up to 256 entries holds the automaton, one entry per state. An entry carries four 8-bit successor pointers and a candidate-match vector with one bit per string of the rule group. A set bit means that, seen through this tile's slice alone, that string may have ended on the byte just consumed. On each enabled cycle the slice selects one pointer of the current state's entry, that pointer becomes the new state, and the new state's candidate-match vector is registered onto the output. Neighbouring tiles AND their vectors together; that step lies outside this block.

Software or a loader fills the table through a single write port, one entry per cycle. A write always takes precedence over stepping in the same cycle.

Top module: `bsplit_tile`

## Requirements
- R1: While reset is low and after it is released, the state is 0 and the match vector is all zero. Reset also clears every table entry, so stepping from a freshly reset tile stays in state 0 with a zero vector for any slice value.
- R2: On a rising edge with `step_en` high and `cfg_we` low, the state becomes pointer k of the current state's entry, where k is the value of `slice_in`. Pointer k occupies bits [8k+7:8k] of an entry.
- R3: After such a step, `match_vec` equals the match field of the new state's entry, held in bits [PMV_W+31:32].
- R4: With `step_en` low and `cfg_we` low, the state and `match_vec` keep their values, whatever `slice_in` is.
- R5: With `cfg_we` high, the entry at `cfg_addr` is replaced by `cfg_entry` on the rising edge. Later steps use the new contents.
- R6: A cycle with `cfg_we` high performs no step, even when `step_en` is high. The state and `match_vec` hold.
- R7: Steps occur on consecutive cycles with no bubble, one transition per enabled cycle.
- R8: Rewriting the entry of the current state does not change `match_vec` until the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | A new byte slice is valid this cycle |
| slice_in | input | 2 | The 2-bit slice of the current payload byte |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_addr | input | 8 | State index of the entry being written |
| cfg_entry | input | PMV_W+32 | Entry data: four pointers in the low 32 bits, the match field above them |
| cur_state | output | 8 | Current automaton state |
| match_vec | output | PMV_W | Candidate-match vector of the current state |

## Verification
The assertions assume that every input is a known value whenever reset is high, and that `cfg_we` and `step_en` change only between clock edges. The bench drives every input on the falling edge, always to a defined value. Random writes target a small range of states, and random pointers mostly stay in that range, so walks revisit freshly written entries. Write-versus-step collisions and writes to the current state are forced both by hand and at random.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  // state pointer width is fixed; the slice width sets the edge count
  localparam int STATE_W     = 8;
  localparam int SLICE_W     = 2;
  localparam int FANOUT      = 1 << SLICE_W;
  localparam int NUM_STATES  = 1 << STATE_W;
  localparam int PTR_FIELD_W = FANOUT * STATE_W;
endpackage

// File: rtl/bsplit_table.sv
module bsplit_table
  import bsplit_pkg::*;
#(
  parameter int PMV_W = 16,
  localparam int ENTRY_W = PTR_FIELD_W + PMV_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [STATE_W-1:0]     wr_addr,
  input  logic [ENTRY_W-1:0]     wr_data,
  input  logic [STATE_W-1:0]     rd_a_addr,
  output logic [PTR_FIELD_W-1:0] rd_a_ptrs,
  input  logic [STATE_W-1:0]     rd_b_addr,
  output logic [PMV_W-1:0]       rd_b_pmv
);

  logic [ENTRY_W-1:0] rows [NUM_STATES];

  // one register row per state, each with its own write enable
  for (genvar gi = 0; gi < NUM_STATES; gi++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_addr == STATE_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rows[gi] <= '0;
      end else if (row_we) begin
        rows[gi] <= wr_data;
      end
    end
  end

  logic [ENTRY_W-1:0] row_a;
  logic [ENTRY_W-1:0] row_b;

  always_comb begin
    row_a     = rows[rd_a_addr];
    row_b     = rows[rd_b_addr];
    rd_a_ptrs = row_a[PTR_FIELD_W-1:0];
    rd_b_pmv  = row_b[ENTRY_W-1:PTR_FIELD_W];
  end

endmodule

// File: rtl/bsplit_edge_sel.sv
module bsplit_edge_sel
  import bsplit_pkg::*;
(
  input  logic [PTR_FIELD_W-1:0] ptrs,
  input  logic [SLICE_W-1:0]     slice,
  output logic [STATE_W-1:0]     succ
);

  logic [STATE_W-1:0] edge_ptr [FANOUT];

  // unpack the pointer field, pointer k at bits [8k+7:8k]
  for (genvar gk = 0; gk < FANOUT; gk++) begin : g_edge
    assign edge_ptr[gk] = ptrs[gk*STATE_W +: STATE_W];
  end

  always_comb begin
    succ = edge_ptr[slice];
  end

endmodule

// File: rtl/bsplit_state_reg.sv
module bsplit_state_reg
  import bsplit_pkg::*;
#(
  parameter int PMV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [STATE_W-1:0] succ,
  input  logic [PMV_W-1:0]   succ_pmv,
  output logic [STATE_W-1:0] state_q,
  output logic [PMV_W-1:0]   pmv_q
);

  logic [STATE_W-1:0] state_d;
  logic [PMV_W-1:0]   pmv_d;

  always_comb begin
    state_d = state_q;
    pmv_d   = pmv_q;
    if (adv) begin
      state_d = succ;
      pmv_d   = succ_pmv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      pmv_q   <= '0;
    end else begin
      state_q <= state_d;
      pmv_q   <= pmv_d;
    end
  end

endmodule

// File: rtl/bsplit_tile.sv
module bsplit_tile
  import bsplit_pkg::*;
#(
  parameter int PMV_W = 16,
  localparam int ENTRY_W = PTR_FIELD_W + PMV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [SLICE_W-1:0] slice_in,
  input  logic               cfg_we,
  input  logic [STATE_W-1:0] cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_entry,
  output logic [STATE_W-1:0] cur_state,
  output logic [PMV_W-1:0]   match_vec
);

  logic [PTR_FIELD_W-1:0] cur_ptrs;
  logic [STATE_W-1:0]     nxt_state;
  logic [PMV_W-1:0]       nxt_pmv;
  logic                   adv;

  // a table write owns the cycle
  assign adv = step_en && !cfg_we;

  bsplit_table #(.PMV_W(PMV_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_entry),
    .rd_a_addr (cur_state),
    .rd_a_ptrs (cur_ptrs),
    .rd_b_addr (nxt_state),
    .rd_b_pmv  (nxt_pmv)
  );

  bsplit_edge_sel u_sel (
    .ptrs  (cur_ptrs),
    .slice (slice_in),
    .succ  (nxt_state)
  );

  bsplit_state_reg #(.PMV_W(PMV_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .succ     (nxt_state),
    .succ_pmv (nxt_pmv),
    .state_q  (cur_state),
    .pmv_q    (match_vec)
  );

endmodule

// File: rtl/bsplit_tile_chk.sv
module bsplit_tile_chk
  import bsplit_pkg::*;
#(
  parameter int PMV_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_en,
  input logic               cfg_we,
  input logic [STATE_W-1:0] cur_state,
  input logic [PMV_W-1:0]   match_vec,
  input logic [STATE_W-1:0] sel_ptr,
  input logic [PMV_W-1:0]   sel_pmv
);

  // R1: outputs sit at the reset state while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (cur_state == '0 && match_vec == '0)
        else $error("reset state violated");
    end
  end

  // R2: a step loads the pointer the selector chose
  assert_step_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cfg_we) |=> cur_state == $past(sel_ptr));

  // R3: a step loads the match field read for the successor
  assert_step_pmv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !cfg_we) |=> match_vec == $past(sel_pmv));

  // R4: idle cycles hold state and vector
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cfg_we) |=> ($stable(cur_state) && $stable(match_vec)));

  // R6: a write cycle never steps
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ($stable(cur_state) && $stable(match_vec)));

endmodule

bind bsplit_tile bsplit_tile_chk #(.PMV_W(PMV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .cfg_we    (cfg_we),
  .cur_state (cur_state),
  .match_vec (match_vec),
  .sel_ptr   (nxt_state),
  .sel_pmv   (nxt_pmv)
);

// File: tb/sim_bsplit_tile.sv
module sim_bsplit_tile;
  localparam int PMV_W = 16;
  localparam int EW    = 32 + PMV_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_en = 1'b0;
  logic [1:0]    slice_in = '0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [EW-1:0] cfg_entry = '0;
  logic [7:0]    cur_state;
  logic [PMV_W-1:0] match_vec;

  always #10 clk = ~clk;

  bsplit_tile #(.PMV_W(PMV_W)) u0 (
    .clk, .rst_n, .step_en, .slice_in, .cfg_we, .cfg_addr, .cfg_entry,
    .cur_state, .match_vec
  );

  logic [EW-1:0]    m_tbl [256];
  logic [7:0]       m_st;
  logic [PMV_W-1:0] m_pmv;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [7:0] ptr_of(logic [EW-1:0] e, int k);
    return e[k*8 +: 8];
  endfunction

  function automatic logic [PMV_W-1:0] pmv_of(logic [EW-1:0] e);
    return e[EW-1:32];
  endfunction

  function automatic logic [EW-1:0] mk(logic [7:0] p0, logic [7:0] p1,
                                       logic [7:0] p2, logic [7:0] p3,
                                       logic [PMV_W-1:0] v);
    return {v, p3, p2, p1, p0};
  endfunction

  task automatic check_out(string tag);
    checks++;
    if (cur_state !== m_st || match_vec !== m_pmv) begin
      fails++;
      $display("FAIL %s: state=%0d pmv=%h expected state=%0d pmv=%h",
               tag, cur_state, match_vec, m_st, m_pmv);
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, check after
  task automatic cyc(input bit we, input bit en, input logic [1:0] sl,
                     input logic [7:0] a, input logic [EW-1:0] d, string tag);
    @(negedge clk);
    cfg_we = we; step_en = en; slice_in = sl; cfg_addr = a; cfg_entry = d;
    @(posedge clk);
    if (we) m_tbl[a] = d;
    else if (en) begin
      m_st  = ptr_of(m_tbl[m_st], int'(sl));
      m_pmv = pmv_of(m_tbl[m_st]);
    end
    #5;
    check_out(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; step_en = 1'b0;
    for (int i = 0; i < 256; i++) m_tbl[i] = '0;
    m_st = '0; m_pmv = '0;
    repeat (2) @(negedge clk);
    check_out("R1 during reset");
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1: cleared table keeps every slice in state 0
    for (int k = 0; k < 4; k++) cyc(0, 1, 2'(k), 8'd0, '0, "R1 cleared table");

    // R5: load a small chain
    cyc(1, 0, 0, 8'd0, mk(8'd1, 8'd2, 8'd3, 8'd4, 16'h0000), "R5 write 0");
    cyc(1, 0, 0, 8'd1, mk(8'd0, 8'd2, 8'd0, 8'd5, 16'h0001), "R5 write 1");
    cyc(1, 0, 0, 8'd2, mk(8'd3, 8'd0, 8'd1, 8'd2, 16'h0010), "R5 write 2");
    cyc(1, 0, 0, 8'd3, mk(8'd4, 8'd4, 8'd0, 8'd1, 16'h0100), "R5 write 3");
    cyc(1, 0, 0, 8'd4, mk(8'd2, 8'd1, 8'd3, 8'd0, 16'h1000), "R5 write 4");
    cyc(1, 0, 0, 8'd5, mk(8'd0, 8'd0, 8'd0, 8'd0, 16'hA5A5), "R5 write 5");

    // R2 R3: each slice value picks its own pointer
    cyc(0, 1, 2'd2, 8'd0, '0, "R2 R3 slice 2");
    cyc(0, 1, 2'd3, 8'd0, '0, "R2 R3 slice 3");
    cyc(0, 1, 2'd1, 8'd0, '0, "R2 R3 slice 1");
    cyc(0, 1, 2'd0, 8'd0, '0, "R2 R3 slice 0");

    // R4: idle with toggling slice
    for (int k = 0; k < 4; k++) cyc(0, 0, 2'(k), 8'd0, '0, "R4 idle hold");

    // R6: write collides with an enabled step
    cyc(1, 1, 2'd3, 8'd9, mk(8'd7, 8'd7, 8'd7, 8'd7, 16'hFFFF), "R6 write wins");

    // R8: rewrite the current state's entry, vector holds until a step
    cyc(1, 0, 0, m_st, mk(8'd5, 8'd5, 8'd5, 8'd5, 16'h7777), "R8 rewrite current");
    cyc(0, 0, 0, 8'd0, '0, "R8 hold after rewrite");
    cyc(0, 1, 2'd1, 8'd0, '0, "R5 step via rewritten entry");

    // R7: back-to-back steps through the chain
    for (int k = 0; k < 8; k++) cyc(0, 1, 2'(k % 4), 8'd0, '0, "R7 consecutive steps");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit we, en;
      logic [7:0] a;
      logic [EW-1:0] d;
      we = ($urandom % 8) == 0;
      en = ($urandom % 4) != 0;
      a  = (($urandom % 5) == 0) ? m_st : 8'($urandom % 16);
      d  = mk(8'($urandom % 16), 8'($urandom % 16), 8'($urandom % 17),
              8'($urandom), 16'($urandom));
      cyc(we, en, 2'($urandom), a, d, "R2 R3 R6 random");
    end

    // R1: mid-run reset clears table and state
    do_reset();
    for (int k = 0; k < 4; k++) cyc(0, 1, 2'(k), 8'd0, '0, "R1 table cleared again");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule